// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address for a 1 Mbyte space. It holds four 16-bit segment bases: code, data, stack and extra. Each request carries four things: an offset, a tag that names the register the offset came from, an optional segment override, and a flag marking a string-destination access. From these the block picks a segment, shifts it left by four bits and adds the offset. One clock later it presents the result together with a single-cycle valid strobe.

The segment bases load through a plain write port. A request issued in the same cycle as a write still uses the base value from before the write. The address sum drops any carry out of the top bit, so addresses wrap around inside the 1 Mbyte space. A segment spans at most 64 Kbytes above its base.

Top module: `seg_addr_gen`

## Requirements
- R1: `pa_addr` equals the chosen segment value times 16 plus `req_offset`. For example, a stack base of 4000h and an offset of 9F20h give 49F20h.
- R2: The sum is truncated to 20 bits. A carry out of bit 19 is dropped, so a base of FFFFh with an offset of 0020h gives 00010h.
- R3: The tag `req_src` selects the default segment when there is no override and no string-destination flag. The encodings are: 0 = instruction pointer, using code; 1 = stack pointer and 2 = base pointer, both using stack; 3 = source index, 4 = destination index and 5 = general base, all using data.
- R4: When `req_ovr_en` is 1 and `req_str_dst` is 0, `req_ovr_sel` replaces the default segment for any tag. Its encoding is 0 = code, 1 = data, 2 = stack, 3 = extra.
- R5: When `req_str_dst` is 1, the extra segment is used. This holds for any tag and whatever the override fields carry.
- R6: `pa_valid` is high for exactly the cycle after each cycle in which `req_valid` is high, and low otherwise. In a cycle with no request, `pa_addr` keeps its last value.
- R7: Reset (`rst_n` low, synchronous) clears all four segment bases, `pa_valid` and `pa_addr` to zero.
- R8: With `wr_en` high, `wr_data` loads the base selected by `wr_sel`, using the R4 encoding. The new value applies to requests in later cycles. A request in the same cycle as the write uses the old value.
- R9: The reserved tag values 6 and 7 use the data segment by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Segment base write enable |
| wr_sel | input | 2 | Segment to write (0 code, 1 data, 2 stack, 3 extra) |
| wr_data | input | SEG_W | Value to load |
| req_valid | input | 1 | Address request strobe |
| req_offset | input | OFF_W | Offset value |
| req_src | input | 3 | Offset source tag |
| req_ovr_en | input | 1 | Segment override enable |
| req_ovr_sel | input | 2 | Override segment |
| req_str_dst | input | 1 | String-destination access |
| pa_valid | output | 1 | Result strobe, one cycle after a request |
| pa_addr | output | SEG_W+SHIFT | Physical address |

## Verification
The bench builds the block with its default parameters: 16-bit bases, 16-bit offsets and a four-bit shift, which give a 20-bit address. These values reach the wrap at the top of the 1 Mbyte space with a base of FFFFh and small offsets. They also make the stated example (4000h:9F20h gives 49F20h) an exact check. The table of vectors crosses every tag with the override and string-destination cases. Directed tests then cover the same-cycle write ordering, the reserved tags, and a reset in the middle of a run.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [SEG_W-1:0]       wr_data,
  input  logic                   req_valid,
  input  logic [OFF_W-1:0]       req_offset,
  input  logic [2:0]             req_src,
  input  logic                   req_ovr_en,
  input  logic [1:0]             req_ovr_sel,
  input  logic                   req_str_dst,
  output logic                   pa_valid,
  output logic [SEG_W+SHIFT-1:0] pa_addr
);
  localparam int PA_W = SEG_W + SHIFT;
  localparam logic [1:0] SEL_CODE  = 2'd0;
  localparam logic [1:0] SEL_DATA  = 2'd1;
  localparam logic [1:0] SEL_STACK = 2'd2;
  localparam logic [1:0] SEL_EXTRA = 2'd3;

  logic [SEG_W-1:0] seg_q [4];
  logic [1:0]       dflt_sel, use_sel;
  logic [PA_W-1:0]  sum;

  always_comb begin
    case (req_src)
      3'd0:       dflt_sel = SEL_CODE;
      3'd1, 3'd2: dflt_sel = SEL_STACK;
      default:    dflt_sel = SEL_DATA;
    endcase
  end

  assign use_sel = req_str_dst ? SEL_EXTRA :
                   req_ovr_en  ? req_ovr_sel : dflt_sel;

  assign sum = {seg_q[use_sel], {SHIFT{1'b0}}} + PA_W'(req_offset);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) seg_q[i] <= '0;
    end else if (wr_en) begin
      seg_q[wr_sel] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_valid <= 1'b0;
      pa_addr  <= '0;
    end else begin
      pa_valid <= req_valid;
      if (req_valid) pa_addr <= sum;
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int OFF_W = 16,
  parameter int PA_W  = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             req_valid,
  input logic [OFF_W-1:0] req_offset,
  input logic [2:0]       req_src,
  input logic             req_ovr_en,
  input logic [1:0]       req_ovr_sel,
  input logic             req_str_dst,
  input logic             pa_valid,
  input logic [PA_W-1:0]  pa_addr
);
  assert_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> pa_valid);

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !pa_valid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(pa_addr));

  assert_low_nibble_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> pa_addr[3:0] == $past(req_offset[3:0]));

  assert_consistent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid) && !$past(wr_en) && $stable(req_offset) &&
     $stable(req_src) && $stable(req_ovr_en) && $stable(req_ovr_sel) &&
     $stable(req_str_dst)) |=> $stable(pa_addr));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.OFF_W(OFF_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_offset = '0;
  logic [2:0]  req_src = '0;
  logic        req_ovr_en = 1'b0;
  logic [1:0]  req_ovr_sel = '0;
  logic        req_str_dst = 1'b0;
  logic        pa_valid;
  logic [19:0] pa_addr;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  seg_addr_gen u0 (.*);

  // src[42:40] ovr_en[39] ovr_sel[38:37] str[36] offset[35:20] expected[19:0]
  localparam logic [42:0] VEC [13] = '{
    {3'd0, 1'b0, 2'd0, 1'b0, 16'h0100, 20'h12440},
    {3'd1, 1'b0, 2'd0, 1'b0, 16'h9F20, 20'h49F20},
    {3'd2, 1'b0, 2'd0, 1'b0, 16'h0010, 20'h40010},
    {3'd3, 1'b0, 2'd0, 1'b0, 16'h0005, 20'h20005},
    {3'd4, 1'b0, 2'd0, 1'b0, 16'h0006, 20'h20006},
    {3'd5, 1'b0, 2'd0, 1'b0, 16'hFFFF, 20'h2FFFF},
    {3'd3, 1'b1, 2'd2, 1'b0, 16'h0001, 20'h40001},
    {3'd0, 1'b1, 2'd3, 1'b0, 16'h000F, 20'hFFFFF},
    {3'd4, 1'b0, 2'd0, 1'b1, 16'h0020, 20'h00010},
    {3'd4, 1'b1, 2'd0, 1'b1, 16'h0000, 20'hFFFF0},
    {3'd1, 1'b1, 2'd2, 1'b1, 16'h0011, 20'h00001},
    {3'd6, 1'b0, 2'd0, 1'b0, 16'h0003, 20'h20003},
    {3'd7, 1'b0, 2'd0, 1'b0, 16'h0000, 20'h20000}
  };
  localparam string VTAG [13] = '{"R3", "R1", "R3", "R3", "R3", "R3", "R4",
                                  "R4", "R2/R5", "R5", "R5", "R9", "R9"};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_seg(logic [1:0] sel, logic [15:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic request(logic [2:0] src, logic oe, logic [1:0] os, logic sd,
                         logic [15:0] off, string req, logic [19:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_src = src; req_ovr_en = oe; req_ovr_sel = os;
    req_str_dst = sd; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, 32'(pa_valid), 32'd1);
    check(req, 32'(pa_addr), 32'(exp));
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset valid", 32'(pa_valid), 32'd0);
    check("R7 reset addr", 32'(pa_addr), 32'd0);
    rst_n = 1'b1;
    request(3'd1, 1'b0, 2'd0, 1'b0, 16'h0ABC, "R7 zero bases", 20'h00ABC);
    request(3'd4, 1'b0, 2'd0, 1'b1, 16'h0123, "R7 zero extra", 20'h00123);

    wr_seg(2'd0, 16'h1234);
    wr_seg(2'd1, 16'h2000);
    wr_seg(2'd2, 16'h4000);
    wr_seg(2'd3, 16'hFFFF);

    for (int i = 0; i < 13; i++)
      request(VEC[i][42:40], VEC[i][39], VEC[i][38:37], VEC[i][36],
              VEC[i][35:20], VTAG[i], VEC[i][19:0]);

    // R6: idle cycle drops strobe, address holds
    @(negedge clk);
    check("R6 idle valid", 32'(pa_valid), 32'd0);
    check("R6 idle hold", 32'(pa_addr), 32'h20000);

    // R8: same-cycle write uses old base, later request sees new
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h5000;
    req_valid = 1'b1; req_src = 3'd0; req_ovr_en = 1'b0; req_str_dst = 1'b0;
    req_offset = 16'h0000;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R8 old value", 32'(pa_addr), 32'h12340);
    request(3'd0, 1'b0, 2'd0, 1'b0, 16'h0007, "R8 new value", 20'h50007);

    // R7: reset mid-run clears bases and outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 mid reset valid", 32'(pa_valid), 32'd0);
    check("R7 mid reset addr", 32'(pa_addr), 32'd0);
    rst_n = 1'b1;
    request(3'd2, 1'b0, 2'd0, 1'b0, 16'h0042, "R7 stack cleared", 20'h00042);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule